// File: doc/BRIEF.md
# Resize Ratio Coefficient Engine

This block turns a pair of image dimensions into the control word that a pixel resizer consumes. The caller supplies an input size and an output size for each axis: vertical (line count) and horizontal (pixel count). For each axis the engine does three things. It picks a power-of-two pre-decimation code. It divides the decimated span by the output span to get a 14-bit fixed-point step with 13 fractional bits. It then packs both axes into a single 32-bit word.

Sizes the resizer cannot handle are rejected. The error code says which axis broke which rule, and a rejected request yields no word. A step that does not fit in 14 bits is clamped and reported as a warning; the word is still produced.

The caller drives a one-cycle `start_i` with the four sizes and waits for the one-cycle `done_o`. Both axes share one restoring shift-subtract divider. The vertical axis is divided first.

Top module: `rsz_coef_engine`

## Requirements
- R1: An input size above 4096 sets error bit 0 of that axis. An output size above 1024 sets error bit 1 of that axis.
- R2: When output size times 8 is less than the input size, error bit 2 of that axis is set. A ratio of exactly 8:1 is accepted.
- R3: An output size below 2, or an input size of 0, sets error bit 3 of that axis.
- R4: The decimation code starts at 0. The working size is halved, and the code incremented, while the size is above 1024 or at least twice the output size. The code never goes past 2.
- R5: The step is floor(8192*(decimated_size-1)/(output_size-1)).
- R6: A step of 16384 or more is output as 0x3FFF and sets the axis warning bit (`warn_o[1]` vertical, `warn_o[0]` horizontal). The word is still produced and `err_o` stays low.
- R7: The word holds the vertical code in [31:30], the vertical step in [29:16], the horizontal code in [15:14] and the horizontal step in [13:0].
- R8: If either axis has an error, no division runs. `done_o` rises one cycle after the start edge, with `err_o`=1, the word 0 and `warn_o` 0. `err_code_o[7:4]` carries the vertical error bits and `err_code_o[3:0]` the horizontal ones.
- R9: A legal request raises `done_o` for exactly one cycle, 55 cycles after the start edge. `busy_o` is high from the cycle after the start edge until `done_o`, and low while `done_o` is high.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The result and its timing follow the earlier request.
- R11: After reset `busy_o`, `done_o`, `err_o`, `err_code_o`, `warn_o` and the word are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken only when idle |
| v_in_i | input | 13 | Vertical input size |
| v_out_i | input | 13 | Vertical output size |
| h_in_i | input | 13 | Horizontal input size |
| h_out_i | input | 13 | Horizontal output size |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request was rejected |
| err_code_o | output | 8 | Per-axis rule bits, vertical in [7:4] |
| warn_o | output | 2 | Per-axis step clamp, vertical in [1] |
| rsc_word_o | output | 32 | Packed resize control word |

## Verification
The start edge counts as edge 0. A rejected request completes after edge 1. A legal one completes after edge 55: one check cycle, then two divider passes of 26 steps, each followed by a capture cycle. The bench drives `start_i` on a falling edge and counts falling edges until `done_o` is seen. It compares that count with 1 or 55 and samples the word, codes and warnings at that same falling edge. The reference values come from an integer model of the rules in the requirements. Re-issued starts are injected mid-run, and the latency check must still return the first request's count and result.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  localparam int unsigned MAX_IN    = 4096;
  localparam int unsigned MAX_OUT   = 1024;
  localparam int unsigned MAX_RATIO = 8;
  localparam int unsigned MAX_DEC   = 2;
  localparam int unsigned FRAC_W    = 13;
  localparam int unsigned STEP_W    = 14;

  localparam int unsigned SZ_W   = $clog2(MAX_IN + 1);
  localparam int unsigned DEC_W  = $clog2(MAX_DEC + 1);
  localparam int unsigned RAT_SH = $clog2(MAX_RATIO);
  localparam int unsigned QUO_W  = SZ_W + FRAC_W;
  localparam int unsigned AXIS_W = DEC_W + STEP_W;
  localparam int unsigned WORD_W = 2 * AXIS_W;
  localparam int unsigned ERR_W  = 4;
  localparam int unsigned LAT    = 2 * QUO_W + 3;

  typedef struct packed {
    logic size_small;
    logic ratio;
    logic out_big;
    logic in_big;
  } axis_err_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_DIV_V, ST_DIV_H} st_t;

  function automatic logic [STEP_W-1:0] sat_step(input logic [QUO_W-1:0] q);
    if (q >= QUO_W'(1 << STEP_W)) return '1;
    return q[STEP_W-1:0];
  endfunction

  function automatic logic step_ovf(input logic [QUO_W-1:0] q);
    return q >= QUO_W'(1 << STEP_W);
  endfunction
endpackage

// File: rtl/rsz_axis_prep.sv
module rsz_axis_prep
  import rsz_pkg::*;
(
  input  logic [SZ_W-1:0]  in_sz_i,
  input  logic [SZ_W-1:0]  out_sz_i,
  output axis_err_t        err_o,
  output logic [DEC_W-1:0] dec_o,
  output logic [QUO_W-1:0] dividend_o,
  output logic [SZ_W-1:0]  divisor_o
);
  logic [SZ_W:0]        out_x2;
  logic [SZ_W+RAT_SH:0] out_xr;
  logic [SZ_W-1:0]      work;
  logic [DEC_W-1:0]     code;

  assign out_x2 = {out_sz_i, 1'b0};
  assign out_xr = {1'b0, out_sz_i, {RAT_SH{1'b0}}};

  always_comb begin
    err_o.in_big     = in_sz_i > SZ_W'(MAX_IN);
    err_o.out_big    = out_sz_i > SZ_W'(MAX_OUT);
    err_o.ratio      = out_xr < (SZ_W+RAT_SH+1)'(in_sz_i);
    err_o.size_small = (out_sz_i < SZ_W'(2)) || (in_sz_i == '0);
  end

  // bounded halving loop
  always_comb begin
    work = in_sz_i;
    code = '0;
    for (int i = 0; i < int'(MAX_DEC); i++) begin
      if ((work > SZ_W'(MAX_OUT)) || ({1'b0, work} >= out_x2)) begin
        work = work >> 1;
        code = code + 1'b1;
      end
    end
  end

  assign dec_o      = code;
  assign dividend_o = QUO_W'(work - 1'b1) << FRAC_W;
  assign divisor_o  = out_sz_i - 1'b1;

  always_comb begin
    if (!(|err_o)) begin
      assert (dec_o <= DEC_W'(MAX_DEC)); // R4
    end
  end
endmodule

// File: rtl/rsz_divider.sv
module rsz_divider
  import rsz_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [QUO_W-1:0] dividend_i,
  input  logic [SZ_W-1:0]  divisor_i,
  output logic             done_o,
  output logic [QUO_W-1:0] quo_o
);
  localparam int unsigned CNT_W = $clog2(QUO_W + 1);

  logic [SZ_W:0]    rem_q;
  logic [QUO_W-1:0] quo_q;
  logic [SZ_W-1:0]  dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [SZ_W:0]    shifted;
  logic [SZ_W+1:0]  diff;
  logic             neg;

  assign shifted = {rem_q[SZ_W-1:0], quo_q[QUO_W-1]};
  assign diff    = {1'b0, shifted} - {2'b00, dvs_q};
  assign neg     = diff[SZ_W+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvs_q <= divisor_i;
        cnt_q <= CNT_W'(QUO_W);
      end else if (cnt_q != '0) begin
        rem_q  <= neg ? shifted : diff[SZ_W:0];
        quo_q  <= {quo_q[QUO_W-2:0], ~neg};
        cnt_q  <= cnt_q - 1'b1;
        done_q <= (cnt_q == CNT_W'(1));
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  AST_DIV_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt_q == '0); // R10
  AST_DIV_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R9
  AST_DIV_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> rem_q < {1'b0, dvs_q}); // R5
endmodule

// File: rtl/rsz_coef_engine.sv
module rsz_coef_engine
  import rsz_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SZ_W-1:0]   v_in_i,
  input  logic [SZ_W-1:0]   v_out_i,
  input  logic [SZ_W-1:0]   h_in_i,
  input  logic [SZ_W-1:0]   h_out_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2*ERR_W-1:0] err_code_o,
  output logic [1:0]        warn_o,
  output logic [WORD_W-1:0] rsc_word_o
);
  // axis 1 = vertical, axis 0 = horizontal
  st_t                     state_q;
  logic [1:0][SZ_W-1:0]    in_q, out_q;
  axis_err_t [1:0]         aerr;
  logic [1:0][DEC_W-1:0]   dec;
  logic [1:0][QUO_W-1:0]   dvd;
  logic [1:0][SZ_W-1:0]    dvs;
  logic                    any_err, accept, div_start, div_done, sel_h;
  logic [QUO_W-1:0]        quo;
  logic [STEP_W-1:0]       step_v_q;
  logic                    done_q, err_q;
  logic [2*ERR_W-1:0]      code_q;
  logic [1:0]              warn_q;
  logic [WORD_W-1:0]       word_q;

  assign accept = start_i && (state_q == ST_IDLE);

  for (genvar a = 0; a < 2; a++) begin : g_axis
    rsz_axis_prep u_prep (
      .in_sz_i   (in_q[a]),
      .out_sz_i  (out_q[a]),
      .err_o     (aerr[a]),
      .dec_o     (dec[a]),
      .dividend_o(dvd[a]),
      .divisor_o (dvs[a])
    );
  end

  assign any_err   = |{aerr[1], aerr[0]};
  assign sel_h     = (state_q == ST_DIV_V);
  assign div_start = ((state_q == ST_CHK) && !any_err) ||
                     ((state_q == ST_DIV_V) && div_done);

  rsz_divider u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (div_start),
    .dividend_i(sel_h ? dvd[0] : dvd[1]),
    .divisor_i (sel_h ? dvs[0] : dvs[1]),
    .done_o    (div_done),
    .quo_o     (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      in_q     <= '0;
      out_q    <= '0;
      step_v_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      code_q   <= '0;
      warn_q   <= '0;
      word_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          in_q    <= {v_in_i, h_in_i};
          out_q   <= {v_out_i, h_out_i};
          state_q <= ST_CHK;
        end
        ST_CHK: begin
          code_q <= {aerr[1], aerr[0]};
          warn_q <= '0;
          if (any_err) begin
            err_q   <= 1'b1;
            word_q  <= '0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            err_q   <= 1'b0;
            state_q <= ST_DIV_V;
          end
        end
        ST_DIV_V: if (div_done) begin
          step_v_q  <= sat_step(quo);
          warn_q[1] <= step_ovf(quo);
          state_q   <= ST_DIV_H;
        end
        ST_DIV_H: if (div_done) begin
          word_q    <= {dec[1], step_v_q, dec[0], sat_step(quo)};
          warn_q[0] <= step_ovf(quo);
          done_q    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;
  assign warn_o     = warn_q;
  assign rsc_word_o = word_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_ERR_NO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (rsc_word_o == '0 && warn_o == '0)); // R8
  AST_WARN_V_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && warn_o[1]) |-> (rsc_word_o[WORD_W-DEC_W-1 -: STEP_W] == '1)); // R6
  AST_WARN_H_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && warn_o[0]) |-> (rsc_word_o[STEP_W-1:0] == '1)); // R6
  AST_START_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(in_q) && $stable(out_q))); // R10
  AST_DIV_ONLY_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIV_V) |-> !any_err); // R8
endmodule

// File: tb/tb_rsz_coef_engine.sv
module tb_rsz_coef_engine;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_OK = 55;
  localparam int LAT_ERR = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] v_in = '0, v_out = '0, h_in = '0, h_out = '0;
  logic        busy, done, err;
  logic [7:0]  err_code;
  logic [1:0]  warn;
  logic [31:0] word;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsz_coef_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .v_in_i(v_in), .v_out_i(v_out), .h_in_i(h_in), .h_out_i(h_out),
    .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(err_code),
    .warn_o(warn), .rsc_word_o(word)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void model(input int in_s, input int out_s, output logic [3:0] e,
                                output int dec, output int step, output bit w);
    int s;
    e[0] = in_s > 4096;
    e[1] = out_s > 1024;
    e[2] = out_s * 8 < in_s;
    e[3] = (out_s < 2) || (in_s == 0);
    s = in_s; dec = 0; w = 0; step = 0;
    while (((s > 1024) || (s >= 2 * out_s)) && dec < 2) begin
      s = s >> 1;
      dec++;
    end
    if (out_s >= 2 && s >= 1) step = (8192 * (s - 1)) / (out_s - 1);
    if (step >= 16384) begin step = 16383; w = 1; end
  endfunction

  task automatic run_and_check(input string req, input int vi, input int vo,
                               input int hi, input int ho, input int spoil_at);
    logic [3:0] ev, eh;
    int dv, sv, dh, sh, cnt;
    bit wv, wh, bad;
    logic [31:0] exp_w;
    model(vi, vo, ev, dv, sv, wv);
    model(hi, ho, eh, dh, sh, wh);
    bad = |{ev, eh};
    exp_w = {dv[1:0], sv[13:0], dh[1:0], sh[13:0]};
    @(negedge clk);
    v_in = 13'(vi); v_out = 13'(vo); h_in = 13'(hi); h_out = 13'(ho);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 2) chk(busy == !bad, {req, " busy"}, busy, !bad);
      if (spoil_at != 0 && cnt == spoil_at) begin
        v_in = 13'd200; v_out = 13'd100; h_in = 13'd5000; h_out = 13'd1;
        start = 1'b1;
      end else start = 1'b0;
    end while (!done && cnt < 200);
    chk(cnt == (bad ? LAT_ERR : LAT_OK), {req, " latency"}, cnt, bad ? LAT_ERR : LAT_OK);
    chk(err == bad, {req, " err"}, err, bad);
    chk(err_code == {ev, eh}, {req, " code"}, err_code, {ev, eh});
    chk(word == (bad ? 32'h0 : exp_w), {req, " word"}, word, bad ? 32'h0 : exp_w);
    chk(warn == (bad ? 2'b00 : {wv, wh}), {req, " warn"}, warn, bad ? 2'b00 : {wv, wh});
    chk(!busy, {req, " busy at done"}, busy, 0);
    @(negedge clk);
    chk(!done, {req, " done one cycle"}, done, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !err, "R11 flags", {busy, done, err}, 0);
    chk(word == 0 && err_code == 0 && warn == 0, "R11 data", word, 0);
  endtask

  task automatic t_typical;     run_and_check("R4 R5 R7 halve", 480, 240, 640, 320, 0); endtask
  task automatic t_upscale;     run_and_check("R5 R7 upscale", 100, 200, 640, 480, 0); endtask
  task automatic t_cap;         run_and_check("R4 cap", 4096, 1024, 2048, 1024, 0); endtask
  task automatic t_saturate;    run_and_check("R6 clamp v", 32, 4, 10, 10, 0); endtask
  task automatic t_saturate_h;  run_and_check("R6 clamp h", 300, 300, 64, 8, 0); endtask
  task automatic t_in_big;      run_and_check("R1 R8 in big", 5000, 1000, 100, 100, 0); endtask
  task automatic t_out_big;     run_and_check("R1 R8 out big", 100, 100, 100, 2000, 0); endtask
  task automatic t_ratio;       run_and_check("R2 R8 ratio", 90, 10, 100, 100, 0); endtask
  task automatic t_ratio_edge;  run_and_check("R2 ratio 8to1 ok", 80, 10, 800, 100, 0); endtask
  task automatic t_small;       run_and_check("R3 R8 out one", 100, 100, 50, 1, 0); endtask
  task automatic t_zero_in;     run_and_check("R3 R8 in zero", 0, 10, 100, 100, 0); endtask
  task automatic t_busy_start;  run_and_check("R10 R9 start ignored", 720, 576, 1280, 1000, 20); endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_typical();
    t_upscale();
    t_cap();
    t_saturate();
    t_saturate_h();
    t_in_big();
    t_out_big();
    t_ratio();
    t_ratio_edge();
    t_small();
    t_zero_in();
    t_busy_start();
    t_typical();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule